// File: doc/BRIEF.md
# Parallel Camera Sensor Capture Front-End

This block sits directly behind the pins of a parallel image sensor and runs in the sensor's pixel clock domain. Every rising clock edge it registers a vertical sync, a horizontal sync and a data word of up to ten bits. It turns them into a pixel stream with four flags: pixel valid, start of frame, start of line and end of line. The stream is meant to be written straight into a small input FIFO that is outside this block.

A static mode input picks one of two timing schemes. In gated mode, the horizontal sync stays active for a whole line, and only clock edges inside that window carry data. In non-gated mode, the horizontal sync is ignored and every clock edge after a frame start carries a byte. The sensor stops its clock between transfers, so line boundaries come from a programmed pixels-per-line count. Each sync input has its own inversion bit. A frame and line counter pair reports progress.

The controller is a four-state machine:
- HUNT: waiting for the first accepted frame; everything received here is dropped.
- ARMED: a frame has started and its first pixel has not yet arrived.
- LINE: inside a line.
- GAP: gated mode only; the horizontal sync is inactive between lines.

Transitions:
- HUNT to ARMED on a vertical sync rise while enabled.
- ARMED to LINE on the first qualified pixel.
- LINE to GAP when the horizontal sync drops (gated mode).
- GAP to LINE when the horizontal sync returns.
- Any of ARMED, LINE or GAP to ARMED on a vertical sync rise while enabled, or to HUNT on a vertical sync rise while disabled.

Top module: `cam_capture`

## Requirements
- R1: After reset, out_valid, out_sof, out_sol and out_eol are 0, and frame_cnt and line_cnt are 0.
- R2: No pixel is output before the first accepted frame start after reset, nor after a frame start that arrives while cfg_enable is 0.
- R3: A frame starts on a rising edge of the vertical sync after optional inversion: cfg_vs_inv=1 makes a high-to-low input transition the frame start. The sampled word on that edge is not output.
- R4: The first pixel output after a frame start has out_sof=1 and out_sol=1. No other pixel has out_sof=1.
- R5: In gated mode (cfg_gated=1), a pixel is output only for edges where the horizontal sync, after inversion by cfg_hs_inv, is 1. All 10 data bits are passed. The first pixel of each line has out_sol=1.
- R6: In gated mode, the first edge with horizontal sync inactive after a line produces a one-cycle out_eol=1 with out_valid=0, and line_cnt increments on that same cycle.
- R7: In non-gated mode (cfg_gated=0), the horizontal sync is ignored. Every edge after a frame start yields a pixel, with out_data[9:8]=0 and out_data[7:0] equal to the sampled data[7:0].
- R8: In non-gated mode, pixels are numbered from 0 at each frame start, modulo cfg_line_len. Pixel 0 of each line has out_sol=1, the last pixel of each line has out_eol=1, and line_cnt increments with each out_eol.
- R9: frame_cnt increments by one at each accepted frame start, and line_cnt returns to 0 there.
- R10: Deasserting cfg_enable does not stop the current frame. It takes effect at the next vertical sync rise, which returns the block to HUNT.
- R11: A word sampled at clock edge k appears on the outputs after edge k+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Capture enable, sampled only at frame starts |
| cfg_gated | input | 1 | 1 = gated (horizontal sync qualifies), 0 = non-gated |
| cfg_vs_inv | input | 1 | Invert vertical sync before edge detection |
| cfg_hs_inv | input | 1 | Invert horizontal sync |
| cfg_line_len | input | CW (12) | Pixels per line in non-gated mode |
| vsync | input | 1 | Sensor vertical sync |
| hsync | input | 1 | Sensor horizontal sync |
| pix_data | input | DW (10) | Sensor data bus |
| out_valid | output | 1 | Pixel word valid |
| out_data | output | DW (10) | Pixel word |
| out_sof | output | 1 | First pixel of a frame |
| out_sol | output | 1 | First pixel of a line |
| out_eol | output | 1 | End of line marker |
| frame_cnt | output | FW (16) | Accepted frames since reset |
| line_cnt | output | LW (12) | Completed lines in the current frame |

## Verification
Every input word passes two registers: the input stage at edge k and the output register at edge k+1. Every flag and counter change for that word is therefore visible after edge k+1. The bench drives inputs just after a rising edge and records each drive's cycle index. A negative-edge monitor logs all outputs per cycle, and each check reads the log at the drive index plus two. The first-pixel check also reads the log at plus one, to confirm nothing appears early. End-of-line and counter checks in gated mode are read at the index of the first inactive-sync drive plus two.

// File: rtl/cam_pkg.sv
package cam_pkg;
    typedef enum logic [1:0] {
        ST_HUNT,
        ST_ARMED,
        ST_LINE,
        ST_GAP
    } cap_state_t;
endpackage

// File: rtl/cam_in_stage.sv
module cam_in_stage #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vs_inv,
    input  logic          hs_inv,
    input  logic          vsync,
    input  logic          hsync,
    input  logic [DW-1:0] data,
    output logic          hs_act,
    output logic          vs_rise,
    output logic [DW-1:0] data_q
);
    logic vs_q;
    logic vs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_q    <= 1'b0;
            vs_prev <= 1'b0;
            hs_act  <= 1'b0;
            data_q  <= '0;
        end else begin
            vs_q    <= vsync ^ vs_inv;
            vs_prev <= vs_q;
            hs_act  <= hsync ^ hs_inv;
            data_q  <= data;
        end
    end

    assign vs_rise = vs_q & ~vs_prev;
endmodule

// File: rtl/cam_col_count.sv
module cam_col_count #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] len,
    output logic          first,
    output logic          last
);
    logic [CW-1:0] col;

    assign first = (col == '0);
    assign last  = ({1'b0, col} + {{CW{1'b0}}, 1'b1}) >= {1'b0, len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col <= '0;
        end else if (clr) begin
            col <= '0;
        end else if (step) begin
            col <= last ? '0 : col + 1'b1;
        end
    end
endmodule

// File: rtl/cam_capture.sv
module cam_capture
    import cam_pkg::*;
#(
    parameter int DW  = 10,
    parameter int NGW = 8,
    parameter int CW  = 12,
    parameter int FW  = 16,
    parameter int LW  = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic          cfg_gated,
    input  logic          cfg_vs_inv,
    input  logic          cfg_hs_inv,
    input  logic [CW-1:0] cfg_line_len,
    input  logic          vsync,
    input  logic          hsync,
    input  logic [DW-1:0] pix_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sof,
    output logic          out_sol,
    output logic          out_eol,
    output logic [FW-1:0] frame_cnt,
    output logic [LW-1:0] line_cnt
);
    cap_state_t    state, nxt;
    logic          hs_act, vs_rise;
    logic [DW-1:0] data_q, narrow_d;
    logic          col_first, col_last;
    logic          take, enter_frame, emit, sof_c, sol_c, eol_c;

    cam_in_stage #(.DW(DW)) u_in (
        .clk(clk), .rst_n(rst_n), .vs_inv(cfg_vs_inv), .hs_inv(cfg_hs_inv),
        .vsync(vsync), .hsync(hsync), .data(pix_data),
        .hs_act(hs_act), .vs_rise(vs_rise), .data_q(data_q)
    );

    cam_col_count #(.CW(CW)) u_col (
        .clk(clk), .rst_n(rst_n), .clr(vs_rise), .step(emit && !cfg_gated),
        .len(cfg_line_len), .first(col_first), .last(col_last)
    );

    generate
        if (DW > NGW) begin : g_pad
            assign narrow_d = {{(DW-NGW){1'b0}}, data_q[NGW-1:0]};
        end else begin : g_same
            assign narrow_d = data_q;
        end
    endgenerate

    assign take        = cfg_gated ? hs_act : 1'b1;
    assign enter_frame = vs_rise && cfg_enable;
    assign emit        = !vs_rise && take && (state != ST_HUNT);
    assign sof_c       = emit && (state == ST_ARMED);
    assign sol_c       = emit && (cfg_gated ? (state == ST_ARMED || state == ST_GAP) : col_first);
    assign eol_c       = cfg_gated ? (!vs_rise && state == ST_LINE && !hs_act)
                                   : (emit && col_last);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT:  if (enter_frame) nxt = ST_ARMED;
            ST_ARMED: if (vs_rise) nxt = enter_frame ? ST_ARMED : ST_HUNT;
                      else if (take) nxt = ST_LINE;
            ST_LINE:  if (vs_rise) nxt = enter_frame ? ST_ARMED : ST_HUNT;
                      else if (!take) nxt = ST_GAP;
            ST_GAP:   if (vs_rise) nxt = enter_frame ? ST_ARMED : ST_HUNT;
                      else if (take) nxt = ST_LINE;
            default:  nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_sol   <= 1'b0;
            out_eol   <= 1'b0;
            frame_cnt <= '0;
            line_cnt  <= '0;
        end else begin
            out_valid <= emit;
            out_data  <= cfg_gated ? data_q : narrow_d;
            out_sof   <= sof_c;
            out_sol   <= sol_c;
            out_eol   <= eol_c;
            if (enter_frame) begin
                frame_cnt <= frame_cnt + 1'b1;
                line_cnt  <= '0;
            end else if (vs_rise) begin
                line_cnt  <= '0;
            end else if (eol_c) begin
                line_cnt  <= line_cnt + 1'b1;
            end
        end
    end

    // R2: nothing leaves the block while hunting for a frame
    p_hunt_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |=> !out_valid);

    // R4: a frame marker is always a valid line-start pixel
    p_sof_is_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && out_sol));

    // R6: gated end-of-line pulse carries no data
    p_gated_eol_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eol && $past(cfg_gated)) |-> !out_valid);

    // R7: narrow mode leaves the upper bits clear
    p_narrow_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(cfg_gated)) |-> (out_data >> NGW) == '0);

    // R9: line count is zero on a frame's first pixel, frames step by one
    p_lines_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (line_cnt == '0));
    p_frame_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_cnt) |-> (frame_cnt == $past(frame_cnt) + 1'b1));
endmodule

// File: tb/test_cam_capture.sv
`timescale 1ns/1ps
module test_cam_capture;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b1, cfg_gated = 1'b1, cfg_vs_inv = 1'b0, cfg_hs_inv = 1'b0;
    logic [11:0] cfg_line_len = 12'd3;
    logic vsync = 1'b0, hsync = 1'b0;
    logic [9:0] pix_data = '0;
    logic out_valid, out_sof, out_sol, out_eol;
    logic [9:0] out_data;
    logic [15:0] frame_cnt;
    logic [11:0] line_cnt;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    logic       m_v [0:8191];
    logic       m_sf[0:8191];
    logic       m_sl[0:8191];
    logic       m_el[0:8191];
    logic [9:0] m_d [0:8191];
    int         m_fc[0:8191];
    int         m_lc[0:8191];

    always #2 clk = ~clk;

    cam_capture i_cam_capture (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_gated(cfg_gated),
        .cfg_vs_inv(cfg_vs_inv), .cfg_hs_inv(cfg_hs_inv), .cfg_line_len(cfg_line_len),
        .vsync(vsync), .hsync(hsync), .pix_data(pix_data),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_sol(out_sol), .out_eol(out_eol), .frame_cnt(frame_cnt), .line_cnt(line_cnt)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc < 8192) begin
            m_v[cyc]  <= out_valid;
            m_sf[cyc] <= out_sof;
            m_sl[cyc] <= out_sol;
            m_el[cyc] <= out_eol;
            m_d[cyc]  <= out_data;
            m_fc[cyc] <= int'(frame_cnt);
            m_lc[cyc] <= int'(line_cnt);
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drv(input logic v, input logic h, input logic [9:0] d, output int c);
        @(posedge clk);
        #1;
        vsync = v; hsync = h; pix_data = d;
        c = cyc;
    endtask

    task automatic idle(input int n);
        int c;
        for (int i = 0; i < n; i++) drv(vsync, hsync, 10'h0, c);
    endtask

    task automatic pix(input string req, input int c, input int v, input int sf,
                       input int sl, input int el, input int d);
        chk(req, "valid", int'(m_v[c+2]), v);
        chk(req, "sof",   int'(m_sf[c+2]), sf);
        chk(req, "sol",   int'(m_sl[c+2]), sl);
        chk(req, "eol",   int'(m_el[c+2]), el);
        if (v != 0) chk(req, "data", int'(m_d[c+2]), d);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "valid", int'(out_valid), 0);
        chk("R1", "sof",   int'(out_sof), 0);
        chk("R1", "sol",   int'(out_sol), 0);
        chk("R1", "eol",   int'(out_eol), 0);
        chk("R1", "frame_cnt", int'(frame_cnt), 0);
        chk("R1", "line_cnt",  int'(line_cnt), 0);
        #1 rst_n = 1'b1;
    endtask

    task automatic t_hunt();
        int c[4];
        for (int i = 0; i < 4; i++) drv(1'b0, 1'b1, 10'h100 + 10'(i), c[i]);
        idle(3);
        for (int i = 0; i < 4; i++) chk("R2", "valid before frame", int'(m_v[c[i]+2]), 0);
        chk("R2", "frame_cnt", m_fc[c[3]+2], 0);
    endtask

    task automatic t_gated();
        int c[9];
        drv(1'b1, 1'b0, 10'h000, c[0]);
        drv(1'b1, 1'b1, 10'h3A5, c[1]);
        drv(1'b1, 1'b1, 10'h001, c[2]);
        drv(1'b1, 1'b1, 10'h2FF, c[3]);
        drv(1'b1, 1'b0, 10'h000, c[4]);
        drv(1'b1, 1'b0, 10'h000, c[5]);
        drv(1'b1, 1'b1, 10'h155, c[6]);
        drv(1'b1, 1'b1, 10'h0AA, c[7]);
        drv(1'b1, 1'b0, 10'h000, c[8]);
        idle(3);
        chk("R3", "sync edge word", int'(m_v[c[0]+2]), 0);
        chk("R3", "frame_cnt", m_fc[c[0]+2], 1);
        chk("R11", "no early output", int'(m_v[c[1]+1]), 0);
        pix("R4", c[1], 1, 1, 1, 0, 'h3A5);
        pix("R5", c[2], 1, 0, 0, 0, 'h001);
        pix("R5", c[3], 1, 0, 0, 0, 'h2FF);
        chk("R9", "line_cnt at sof", m_lc[c[1]+2], 0);
        pix("R6", c[4], 0, 0, 0, 1, 0);
        chk("R6", "line_cnt step", m_lc[c[4]+2], 1);
        pix("R5", c[5], 0, 0, 0, 0, 0);
        pix("R5", c[6], 1, 0, 1, 0, 'h155);
        pix("R5", c[7], 1, 0, 0, 0, 'h0AA);
        pix("R6", c[8], 0, 0, 0, 1, 0);
        chk("R6", "line_cnt second", m_lc[c[8]+2], 2);
    endtask

    task automatic t_polarity();
        int c[4];
        cfg_vs_inv = 1'b1;
        cfg_hs_inv = 1'b1;
        drv(1'b1, 1'b1, 10'h000, c[0]);
        drv(1'b0, 1'b1, 10'h000, c[1]);
        drv(1'b0, 1'b0, 10'h2C3, c[2]);
        drv(1'b0, 1'b1, 10'h000, c[3]);
        idle(3);
        chk("R3", "inactive level quiet", int'(m_v[c[0]+2]), 0);
        chk("R3", "inverted frame start", m_fc[c[1]+2], 2);
        chk("R9", "line_cnt cleared", m_lc[c[1]+2], 0);
        pix("R5", c[2], 1, 1, 1, 0, 'h2C3);
        pix("R6", c[3], 0, 0, 0, 1, 0);
    endtask

    task automatic t_nongated();
        int c0, c1;
        int c[7];
        cfg_vs_inv = 1'b0;
        cfg_hs_inv = 1'b0;
        cfg_gated  = 1'b0;
        cfg_line_len = 12'd3;
        drv(1'b0, 1'b0, 10'h000, c0);
        drv(1'b1, 1'b0, 10'h000, c1);
        for (int k = 0; k < 7; k++) drv(1'b1, 1'(k % 2), 10'h3F0 + 10'(k), c[k]);
        idle(3);
        chk("R9", "frame_cnt", m_fc[c1+2], 3);
        for (int k = 0; k < 7; k++)
            pix("R7", c[k], 1, (k == 0) ? 1 : 0, (k % 3 == 0) ? 1 : 0,
                (k % 3 == 2) ? 1 : 0, (10'h3F0 + k) & 10'h0FF);
        chk("R8", "line_cnt after two lines", m_lc[c[5]+2], 2);
        chk("R8", "line_cnt mid line", m_lc[c[6]+2], 2);
    endtask

    task automatic t_enable();
        int a, b, f1, f2, g1, g2;
        cfg_enable = 1'b0;
        drv(1'b1, 1'b0, 10'h011, a);
        drv(1'b0, 1'b0, 10'h012, b);
        drv(1'b1, 1'b0, 10'h022, f1);
        drv(1'b1, 1'b0, 10'h033, f2);
        idle(3);
        chk("R10", "frame continues", int'(m_v[a+2]), 1);
        chk("R10", "frame continues 2", int'(m_v[b+2]), 1);
        chk("R10", "stopped at sync", int'(m_v[f1+2]), 0);
        chk("R2", "dropped while disabled", int'(m_v[f2+2]), 0);
        chk("R10", "frame_cnt held", m_fc[f2+2], 3);
        cfg_enable = 1'b1;
        drv(1'b0, 1'b0, 10'h000, g1);
        drv(1'b1, 1'b0, 10'h000, g1);
        drv(1'b1, 1'b0, 10'h044, g2);
        idle(3);
        chk("R10", "frame_cnt resumed", m_fc[g1+2], 4);
        pix("R4", g2, 1, 1, 1, 0, 'h044);
    endtask

    initial begin
        t_reset();
        t_hunt();
        t_gated();
        t_polarity();
        t_nongated();
        t_enable();
        summary();
    end
endmodule